// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a single-clock synchronous static memory. It lets a bus run back-to-back reads and writes with no idle cycle between them. A read returns data combinationally, in the same cycle, from the address registered at the most recent active edge. A write takes its address and byte enables at one edge and its data at the next edge. That write data waits in a late-write register and is committed to the array at the following active edge. Any read of that address in the meantime is served from the register, so reads stay coherent with writes still in flight.

Each word is 36 bits wide, made of four 9-bit lanes. The address depth is a parameter so the model can be kept small. An access starts either with a load of an external address or by continuing a burst. A burst steps a 2-bit offset in linear or interleaved order. The other controls are:
- a hold input, which freezes the whole pipeline;
- a sleep input, which makes the block ignore all its other inputs while keeping the array contents;
- an asynchronous output enable, which gates the read-data valid flag.

The bidirectional data pin is split into separate `din`, `dout` and `dout_en` signals.

Top module: `tsram_top`

## Requirements
- R1: At an active edge with `burst_cont` low, the block loads `addr`. `rd_nwr` then sets the cycle type: 1 is a read, 0 is a write.
- R2: At an active edge with `burst_cont` high, `rd_nwr` is ignored and the cycle keeps the type and selection of the last load. A read never turns into a write, or a write into a read, without a new load.
- R3: The block is selected when `cs_n`=0, `cs_hi`=1 and `cs2_n`=0. These three inputs are sampled only on a load. Any other value deselects the block: `dout_en` stays 0, no write takes place, and the deselect lasts through any burst that follows it. After reset no access is active.
- R4: A write is late. Its address and `be_n` are taken at edge N, and its data is taken from `din` at the next active edge N+1.
- R5: `be_n` is active low. Bit 0 controls data bits [8:0], bit 1 controls [17:9], bit 2 controls [26:18] and bit 3 controls [35:27]. Only the enabled lanes change.
- R6: On a load the burst offset starts at `addr[1:0]`. With `burst_ilv`=0, each continue adds 1 to the low two address bits, modulo 4.
- R7: With `burst_ilv`=1, the low two address bits equal the start offset XOR the access count (0, 1, 2, 3).
- R8: During a burst the address bits above bit 1 stay fixed. The sequence wraps after the fourth access.
- R9: While `hold` is high, every clock edge is ignored. All pipeline state holds and the outputs stay as they were.
- R10: While `sleep` is high, all other inputs are ignored, `dout_en` is 0, and the array contents are kept.
- R11: During a selected read, `dout` carries the word at the address registered at the most recent active edge, and it is valid before the next edge.
- R12: `out_en_n` is asynchronous and active low. When it is high, `dout_en` is 0.
- R13: A read of an address whose data is still in the late-write register returns the stored word with the pending enabled lanes replaced by the new values.
- R14: A write followed at once by a deselect still completes, with its data taken during the deselect cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | High: ignore this clock edge |
| sleep | input | 1 | High: ignore all inputs, keep contents |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| cs_n | input | 1 | Active-low select, sampled on load |
| cs_hi | input | 1 | Active-high select, sampled on load |
| cs2_n | input | 1 | Second active-low select, sampled on load |
| burst_cont | input | 1 | High: continue burst; low: load address |
| rd_nwr | input | 1 | Cycle type on load: 1 read, 0 write |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| be_n | input | 4 | Active-low lane write enables |
| addr | input | ADDR_W | Word address |
| din | input | 36 | Write data, one active edge after its address |
| dout | output | 36 | Read data (zero when not valid) |
| dout_en | output | 1 | Read data valid / drive enable |

## Verification
The embedded assertions check the cycle-level rules on every edge:
- the burst offset restarts on a load and steps by one on a continue;
- a continue keeps the cycle type and selection;
- every state register holds while the edge is ignored;
- each write cycle fills the late-write register one edge later with the same address and data, and no other cycle does;
- a deselecting load leaves `dout_en` low.

Data values can only be shown by the bench scenarios, which compare `dout` against a reference model of the array. These scenarios cover:
- partial-lane merges;
- reads that hit the pending write;
- linear and interleaved wrap order;
- reads during hold and sleep;
- a write completing across a deselect.

// File: rtl/tsram_pkg.sv
package tsram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // Offset within a four-beat burst for the given start and beat count.
    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input logic               ilv
    );
        logic [BURST_W-1:0] r;
        if (ilv) r = start ^ beat;
        else     r = start + beat;
        return r;
    endfunction

    // Three-way select decode applied at a load.
    function automatic logic chip_selected(
        input logic sel_a_n,
        input logic sel_b,
        input logic sel_c_n
    );
        return !sel_a_n && sel_b && !sel_c_n;
    endfunction

endpackage

// File: rtl/tsram_seq.sv
module tsram_seq
    import tsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              load,
    input  logic              sel_ok,
    input  logic              rd_nwr,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be_n,
    output logic              cyc_valid,
    output op_e               cyc_op,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [LANES-1:0]  cyc_be_n
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    hi_q;
    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_valid <= 1'b0;
            cyc_op    <= OP_READ;
            hi_q      <= '0;
            start_q   <= '0;
            beat_q    <= '0;
            cyc_be_n  <= '1;
        end else if (advance) begin
            cyc_be_n <= be_n;
            if (load) begin
                cyc_valid <= sel_ok;
                cyc_op    <= rd_nwr ? OP_READ : OP_WRITE;
                hi_q      <= addr[ADDR_W-1:BURST_W];
                start_q   <= addr[BURST_W-1:0];
                beat_q    <= '0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign cyc_addr = {hi_q, burst_offset(start_q, beat_q, ilv)};

    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        advance && load |=> beat_q == '0 && start_q == $past(addr[BURST_W-1:0])) // R6
        else $error("burst offset not restarted on load");

    AST_BEAT_STEPS: assert property (@(posedge clk) disable iff (rst)
        advance && !load |=> beat_q == $past(beat_q) + 1'b1 && hi_q == $past(hi_q)) // R8
        else $error("burst beat did not step");

    AST_TYPE_KEPT: assert property (@(posedge clk) disable iff (rst)
        advance && !load |=> cyc_op == $past(cyc_op) && cyc_valid == $past(cyc_valid)) // R2
        else $error("cycle type changed without load");

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable({cyc_valid, cyc_op, hi_q, start_q, beat_q, cyc_be_n})) // R9
        else $error("state moved on ignored edge");

endmodule

// File: rtl/tsram_lwbuf.sv
module tsram_lwbuf
    import tsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              cyc_valid,
    input  op_e               cyc_op,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [LANES-1:0]  cyc_be_n,
    input  logic [WORD_W-1:0] din,
    output logic              lw_valid,
    output logic [ADDR_W-1:0] lw_addr,
    output logic [LANES-1:0]  lw_be_n,
    output logic [WORD_W-1:0] lw_data
);

    logic wr_now;
    assign wr_now = cyc_valid && (cyc_op == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            lw_valid <= 1'b0;
            lw_addr  <= '0;
            lw_be_n  <= '1;
            lw_data  <= '0;
        end else if (advance) begin
            lw_valid <= wr_now;
            lw_addr  <= cyc_addr;
            lw_be_n  <= cyc_be_n;
            lw_data  <= din;
        end
    end

    AST_LATE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        advance && wr_now |=> lw_valid && lw_addr == $past(cyc_addr) && lw_data == $past(din)) // R4
        else $error("late write data not captured");

    AST_NO_GHOST_WRITE: assert property (@(posedge clk) disable iff (rst)
        advance && !wr_now |=> !lw_valid) // R3
        else $error("write queued without a selected write cycle");

endmodule

// File: rtl/tsram_store.sv
module tsram_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              advance,
    input  logic              lw_valid,
    input  logic [ADDR_W-1:0] lw_addr,
    input  logic [LANES-1:0]  lw_be_n,
    input  logic [WORD_W-1:0] lw_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic hit;
    assign hit = lw_valid && (lw_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] pend;

        assign pend = lw_data[g*LANE_W +: LANE_W];

        always_ff @(posedge clk) begin
            if (advance && lw_valid && !lw_be_n[g])
                mem[lw_addr] <= pend;
        end

        assign rd_word[g*LANE_W +: LANE_W] =
            (hit && !lw_be_n[g]) ? pend : mem[rd_addr];
    end

endmodule

// File: rtl/tsram_top.sv
module tsram_top
    import tsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              sleep,
    input  logic              out_en_n,
    input  logic              cs_n,
    input  logic              cs_hi,
    input  logic              cs2_n,
    input  logic              burst_cont,
    input  logic              rd_nwr,
    input  logic              burst_ilv,
    input  logic [LANES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    logic              advance;
    logic              load;
    logic              sel_ok;
    logic              cyc_valid;
    op_e               cyc_op;
    logic [ADDR_W-1:0] cyc_addr;
    logic [LANES-1:0]  cyc_be_n;
    logic              lw_valid;
    logic [ADDR_W-1:0] lw_addr;
    logic [LANES-1:0]  lw_be_n;
    logic [WORD_W-1:0] lw_data;
    logic [WORD_W-1:0] rd_word;

    assign advance = !hold && !sleep;
    assign load    = !burst_cont;
    assign sel_ok  = chip_selected(cs_n, cs_hi, cs2_n);

    tsram_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
        .clk(clk), .rst(rst), .advance(advance), .load(load),
        .sel_ok(sel_ok), .rd_nwr(rd_nwr), .ilv(burst_ilv),
        .addr(addr), .be_n(be_n),
        .cyc_valid(cyc_valid), .cyc_op(cyc_op),
        .cyc_addr(cyc_addr), .cyc_be_n(cyc_be_n)
    );

    tsram_lwbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lw (
        .clk(clk), .rst(rst), .advance(advance),
        .cyc_valid(cyc_valid), .cyc_op(cyc_op),
        .cyc_addr(cyc_addr), .cyc_be_n(cyc_be_n), .din(din),
        .lw_valid(lw_valid), .lw_addr(lw_addr),
        .lw_be_n(lw_be_n), .lw_data(lw_data)
    );

    tsram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk), .advance(advance),
        .lw_valid(lw_valid), .lw_addr(lw_addr),
        .lw_be_n(lw_be_n), .lw_data(lw_data),
        .rd_addr(cyc_addr), .rd_word(rd_word)
    );

    assign dout_en = cyc_valid && (cyc_op == OP_READ) && !out_en_n && !sleep;
    assign dout    = dout_en ? rd_word : '0;

    AST_DESELECT_DARK: assert property (@(posedge clk) disable iff (rst)
        advance && load && !sel_ok |=> !dout_en) // R3
        else $error("output enabled after deselect");

    AST_WRITE_LOAD_DARK: assert property (@(posedge clk) disable iff (rst)
        advance && load && !rd_nwr |=> !dout_en) // R1
        else $error("output enabled during write cycle");

endmodule

// File: tb/tsram_top_tb.sv
module tsram_top_tb;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold = 0, sleep = 0, out_en_n = 0;
    logic        cs_n = 0, cs_hi = 1, cs2_n = 0;
    logic        burst_cont = 1, rd_nwr = 1, burst_ilv = 0;
    logic [3:0]  be_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        dout_en;

    // staged inputs, applied at the falling edge
    logic        s_rst = 1, s_hold = 0, s_sleep = 0, s_oe_n = 0;
    logic        s_cs_n = 0, s_cs_hi = 1, s_cs2_n = 0;
    logic        s_cont = 1, s_rd = 1, s_ilv = 0;
    logic [3:0]  s_be = 4'hF;
    logic [AW-1:0] s_addr = '0;
    logic [35:0] s_din = '0;

    // reference model
    logic [35:0] shadow [DEPTH];
    logic        known  [DEPTH];
    logic        m_v, m_wr;
    logic [AW-1:0] m_base;
    logic [1:0]  m_beat;
    logic [3:0]  m_be;
    logic        l_v;
    logic [AW-1:0] l_a;
    logic [3:0]  l_be;
    logic [35:0] l_d;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    tsram_top #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .hold(hold), .sleep(sleep), .out_en_n(out_en_n),
        .cs_n(cs_n), .cs_hi(cs_hi), .cs2_n(cs2_n), .burst_cont(burst_cont),
        .rd_nwr(rd_nwr), .burst_ilv(burst_ilv), .be_n(be_n), .addr(addr),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #2 clk = ~clk;

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = burst_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic [3:0] ben);
        logic [35:0] r;
        r = old;
        for (int i = 0; i < 4; i++)
            if (!ben[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    function automatic logic [35:0] rnd36();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[35:0];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [35:0] got, input logic [35:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic cyc(input string tag);
        logic [AW-1:0] a;
        logic [35:0]   w;
        logic          hit, exp_en;
        string         t;
        @(negedge clk);
        rst = s_rst; hold = s_hold; sleep = s_sleep; out_en_n = s_oe_n;
        cs_n = s_cs_n; cs_hi = s_cs_hi; cs2_n = s_cs2_n;
        burst_cont = s_cont; rd_nwr = s_rd; burst_ilv = s_ilv;
        be_n = s_be; addr = s_addr; din = s_din;
        #1;
        a      = m_addr();
        w      = shadow[a];
        hit    = l_v && (l_a == a);
        if (hit) w = merge(w, l_d, l_be);
        exp_en = m_v && !m_wr && !out_en_n && !sleep && !rst;
        if (tag != "")      t = tag;
        else if (sleep)     t = "R10";
        else if (out_en_n)  t = "R12";
        else if (!m_v)      t = "R3";
        else if (hit)       t = "R13";
        else if (m_beat != 0) t = burst_ilv ? "R7" : "R6";
        else                t = "R11";
        if (!rst) begin
            check(t, "dout_en", {35'b0, dout_en}, {35'b0, exp_en});
            if (exp_en && known[a]) check(t, "dout", dout, w);
        end
        @(posedge clk);
        if (rst) begin
            m_v = 0; m_wr = 0; m_base = '0; m_beat = 0; m_be = 4'hF;
            l_v = 0; l_a = '0; l_be = 4'hF; l_d = '0;
        end else if (!hold && !sleep) begin
            if (l_v) begin
                shadow[l_a] = merge(shadow[l_a], l_d, l_be);
                if (l_be == 4'h0) known[l_a] = 1'b1;
            end
            l_v  = m_v && m_wr;
            l_a  = m_addr();
            l_be = m_be;
            l_d  = din;
            m_be = be_n;
            if (!burst_cont) begin
                m_v    = !cs_n && cs_hi && !cs2_n;
                m_wr   = !rd_nwr;
                m_base = addr;
                m_beat = 0;
            end else begin
                m_beat = m_beat + 2'd1;
            end
        end
    endtask

    task automatic idle_ctl();
        s_rst = 0; s_hold = 0; s_sleep = 0; s_oe_n = 0;
        s_cs_n = 0; s_cs_hi = 1; s_cs2_n = 0;
    endtask

    task automatic ld(input logic rd, input logic [AW-1:0] a, input logic [3:0] ben,
                      input logic [35:0] d, input string tag);
        idle_ctl();
        s_cont = 0; s_rd = rd; s_addr = a; s_be = ben; s_din = d;
        cyc(tag);
    endtask

    task automatic nx(input logic [35:0] d, input string tag);
        idle_ctl();
        s_cont = 1; s_rd = 0; s_addr = rnd36()[AW-1:0]; s_be = 4'h0; s_din = d;
        cyc(tag);
    endtask

    task automatic dsel(input logic [35:0] d, input string tag);
        idle_ctl();
        s_cs_hi = 0; s_cont = 0; s_rd = 0; s_be = 4'h0; s_din = d;
        cyc(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            shadow[i] = '0;
            known[i]  = 1'b0;
        end
        // reset
        repeat (3) cyc("R3");
        idle_ctl();
        s_cont = 1;
        cyc("R3");   // first cycle after reset: nothing active

        // fill the array with full-word writes, back to back
        for (int a = 0; a < DEPTH; a++)
            ld(1'b0, a[AW-1:0], 4'h0, {a[17:0], ~a[17:0]} ^ 36'h5A5A5A5A5, "R1");
        dsel({(DEPTH-1) , 12'h0} ^ 36'h5A5A5A5A5 ^ {18'(DEPTH-1), ~18'(DEPTH-1)} ^ {(DEPTH-1), 12'h0}, "R4");

        // R1 / R4 / R13: write then immediate read of same address
        ld(1'b0, 6'd5, 4'h0, rnd36(), "R1");
        ld(1'b1, 6'd5, 4'h0, 36'h123456789, "R4");
        ld(1'b1, 6'd5, 4'hF, rnd36(), "R13");
        ld(1'b1, 6'd5, 4'hF, rnd36(), "R1");

        // R5: lanes 0 and 2 only
        ld(1'b0, 6'd9, 4'b1010, rnd36(), "R5");
        ld(1'b1, 6'd9, 4'hF, 36'hFFFFFFFFF, "R5");
        ld(1'b1, 6'd9, 4'hF, rnd36(), "R5");

        // R2 / R8: linear read burst from offset 3, rd_nwr held low
        ld(1'b1, {4'd3, 2'd3}, 4'hF, rnd36(), "R8");
        nx(rnd36(), "R2");
        nx(rnd36(), "R8");
        nx(rnd36(), "R6");
        nx(rnd36(), "R8");

        // R7: interleaved burst from offset 1
        s_ilv = 1;
        ld(1'b1, {4'd7, 2'd1}, 4'hF, rnd36(), "R7");
        repeat (4) nx(rnd36(), "R7");
        s_ilv = 0;
        ld(1'b1, 6'd0, 4'hF, rnd36(), "R11");

        // R9: hold mid-burst, inputs that would load a write
        ld(1'b1, 6'd12, 4'hF, rnd36(), "R9");
        idle_ctl(); s_hold = 1; s_cont = 0; s_rd = 0; s_addr = 6'd40; s_be = 4'h0;
        repeat (3) cyc("R9");
        nx(rnd36(), "R9");

        // R10: sleep ignores a write load, contents kept
        ld(1'b1, 6'd20, 4'hF, rnd36(), "R10");
        idle_ctl(); s_sleep = 1; s_cont = 0; s_rd = 0; s_addr = 6'd20; s_be = 4'h0;
        s_din = rnd36();
        repeat (3) cyc("R10");
        ld(1'b1, 6'd20, 4'hF, rnd36(), "R10");

        // R14: write then deselect, data taken during the deselect
        ld(1'b0, 6'd30, 4'h0, rnd36(), "R14");
        dsel(36'h0BADC0DE5, "R14");
        ld(1'b1, 6'd30, 4'hF, rnd36(), "R14");

        // R12: output enable high during a read
        ld(1'b1, 6'd31, 4'hF, rnd36(), "R12");
        idle_ctl(); s_oe_n = 1; s_cont = 1; cyc("R12");

        // R3: deselect read and its burst
        idle_ctl(); s_cs_n = 1; s_cont = 0; s_rd = 1; s_addr = 6'd2; cyc("R3");
        nx(rnd36(), "R3");
        nx(rnd36(), "R3");

        // constrained random traffic
        for (int k = 0; k < 4000; k++) begin
            idle_ctl();
            s_hold  = ($urandom_range(0, 9) == 0);
            s_sleep = ($urandom_range(0, 19) == 0);
            s_oe_n  = ($urandom_range(0, 9) == 0);
            s_cs_hi = ($urandom_range(0, 9) != 0);
            s_cont  = ($urandom_range(0, 9) < 4);
            s_rd    = $urandom_range(0, 1);
            s_be    = $urandom_range(0, 15);
            s_addr  = $urandom_range(0, 15);
            s_din   = rnd36();
            if (k % 1000 == 0) s_ilv = ~s_ilv;
            cyc("");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule